// File: doc/BRIEF.md
# Low-Power Exit Reset Sequencer

This block decides how the device leaves its deepest low-power state. While the device is parked in that state, one of two events can end it: a wakeup request from the wakeup detector, or assertion of the external reset pin. Neither resumes execution. Both drive the system reset output for a fixed number of clock cycles. Both also set sticky reset-source status flags that outlive that reset, and both raise an indication that retained state has been lost.

The two exit paths differ in how they treat the I/O isolation hold that keeps the pads frozen during low power. After a wakeup exit the hold stays asserted through the reset and afterwards, until software pulses an isolation acknowledge. After a reset-pin exit the hold drops in the same cycle the reset starts, so the pads go straight back to their reset state, and a separate pin-reset flag is recorded.

The wakeup and reset-pin inputs are asynchronous. Each passes through a parameterized synchronizer before the sequencer acts on it.

Top module: `lp_exit_seq`

## Requirements
- R1: After power-on reset (`rst_n` low) the block is in the run state. The outputs `sys_rst_o`, `iso_hold_o`, `flag_wake_o`, `flag_pin_o` and `ret_lost_o` are all 0.
- R2: When `lp_mode_i` is high in the run state, the block enters the low-power state at the next clock edge, and `iso_hold_o` reads 1 from then on.
- R3: In the low-power state, a wakeup or reset-pin request takes effect after passing `SYNC_STAGES` synchronizer flops. `sys_rst_o` rises after the (`SYNC_STAGES`+1)-th clock edge that samples the request and is 0 before it. It then stays 1 for exactly `RST_CYCLES` (default 8) clock cycles.
- R4: Every exit sets `flag_wake_o` and `ret_lost_o` to 1 in the same cycle that `sys_rst_o` rises.
- R5: After a wakeup exit, `iso_hold_o` stays 1 during the reset and after it, until `iso_ack_i` is sampled high. It reads 0 one cycle after that sample, and the block is back in the run state.
- R6: After a reset-pin exit, `iso_hold_o` reads 0 in the same cycle that `sys_rst_o` rises, `flag_pin_o` is set, and the block returns to the run state when the reset ends, without any acknowledge.
- R7: If reset-pin and wakeup requests reach the sequencer in the same cycle, the reset pin wins: `flag_pin_o` is set and isolation is released at once.
- R8: The flags `flag_wake_o`, `flag_pin_o` and `ret_lost_o` hold their value until `flag_clr_i` is sampled high, which clears all three at the next edge. A flag being set in the same cycle as a clear ends up set.
- R9: Wakeup and reset-pin requests outside the low-power state are ignored. No reset starts and no flag changes.
- R10: `iso_ack_i` has no effect during the exit reset. The isolation hold is still 1 after the reset has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low power-on reset |
| lp_mode_i | input | 1 | Request to enter the deep low-power state |
| wake_req_i | input | 1 | Wakeup request from the detector (asynchronous) |
| pin_rst_i | input | 1 | External reset pin, active high (asynchronous) |
| iso_ack_i | input | 1 | Software isolation-acknowledge strobe |
| flag_clr_i | input | 1 | Clear strobe for the status flags |
| sys_rst_o | output | 1 | System reset, active high |
| iso_hold_o | output | 1 | I/O isolation hold |
| flag_wake_o | output | 1 | Sticky flag: exit from low power occurred |
| flag_pin_o | output | 1 | Sticky flag: exit was caused by the reset pin |
| ret_lost_o | output | 1 | Sticky flag: retained state was lost |

## Verification
The exit function is driven four ways. A lone wakeup request, a lone reset-pin request and both requests together separate the two isolation behaviours and confirm the pin's priority. The same requests raised while the block is running show that they are ignored outside low power. An acknowledge pulsed during the reset must not shorten isolation. A clear raised in the same cycle as an exit separates a set-wins flag register from a clear-wins one. The reset edges are sampled one cycle either side of the expected edge, which catches both synchronizer-depth and counter-length errors.

// File: rtl/lpx_pkg.sv
package lpx_pkg;

   typedef enum logic [1:0] {
      ST_RUN      = 2'd0,
      ST_LOWPWR   = 2'd1,
      ST_EXIT_RST = 2'd2,
      ST_ISO_WAIT = 2'd3
   } lpx_state_t;

   typedef struct packed {
      logic fire;
      logic by_pin;
   } lpx_exit_t;

endpackage

// File: rtl/lpx_sync.sv
module lpx_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe_q <= '0;
            end else begin
               pipe_q[0] <= d_i;
               for (int s = 1; s < STAGES; s++) begin
                  pipe_q[s] <= pipe_q[s-1];
               end
            end
         end
         assign q_o = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/lpx_exit_arb.sv
module lpx_exit_arb
   import lpx_pkg::*;
(
   input  logic      armed_i,
   input  logic      wake_i,
   input  logic      pin_i,
   output lpx_exit_t exit_o
);

   // The reset pin outranks the wakeup detector when both are present.
   always_comb begin
      exit_o.fire   = armed_i & (wake_i | pin_i);
      exit_o.by_pin = armed_i & pin_i;
   end

endmodule

// File: rtl/lpx_rst_timer.sv
module lpx_rst_timer #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);

   localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (run_i && cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end else begin
         cnt_q <= '0;
      end
   end

   assign done_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/lpx_status.sv
module lpx_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_exit_i,
   input  logic set_pin_i,
   input  logic clr_i,
   output logic wake_o,
   output logic pin_o,
   output logic lost_o
);

   logic wake_q, pin_q, lost_q;

   // A set in the same cycle as a clear wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_q <= 1'b0;
         pin_q  <= 1'b0;
         lost_q <= 1'b0;
      end else begin
         wake_q <= set_exit_i | (wake_q & ~clr_i);
         pin_q  <= set_pin_i  | (pin_q  & ~clr_i);
         lost_q <= set_exit_i | (lost_q & ~clr_i);
      end
   end

   assign wake_o = wake_q;
   assign pin_o  = pin_q;
   assign lost_o = lost_q;

endmodule

// File: rtl/lp_exit_seq.sv
module lp_exit_seq
   import lpx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int RST_CYCLES  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lp_mode_i,
   input  logic wake_req_i,
   input  logic pin_rst_i,
   input  logic iso_ack_i,
   input  logic flag_clr_i,
   output logic sys_rst_o,
   output logic iso_hold_o,
   output logic flag_wake_o,
   output logic flag_pin_o,
   output logic ret_lost_o
);

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("lp_exit_seq: SYNC_STAGES must lie in 0..4");
      end
      if (RST_CYCLES < 2) begin : g_bad_len
         $error("lp_exit_seq: RST_CYCLES must be at least 2");
      end
   endgenerate

   logic [1:0] req_s;
   logic       wake_s, pin_s;
   lpx_exit_t  exit_ev;
   lpx_state_t state_q, state_d;
   logic       by_pin_q;
   logic       rst_done;

   lpx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({pin_rst_i, wake_req_i}),
      .q_o   (req_s)
   );
   assign wake_s = req_s[0];
   assign pin_s  = req_s[1];

   lpx_exit_arb u_arb (
      .armed_i (state_q == ST_LOWPWR),
      .wake_i  (wake_s),
      .pin_i   (pin_s),
      .exit_o  (exit_ev)
   );

   lpx_rst_timer #(.CYCLES(RST_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state_q == ST_EXIT_RST),
      .done_o (rst_done)
   );

   lpx_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_exit_i (exit_ev.fire),
      .set_pin_i  (exit_ev.by_pin),
      .clr_i      (flag_clr_i),
      .wake_o     (flag_wake_o),
      .pin_o      (flag_pin_o),
      .lost_o     (ret_lost_o)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:      if (lp_mode_i) state_d = ST_LOWPWR;
         ST_LOWPWR:   if (exit_ev.fire) state_d = ST_EXIT_RST;
         ST_EXIT_RST: if (rst_done) state_d = by_pin_q ? ST_RUN : ST_ISO_WAIT;
         ST_ISO_WAIT: if (iso_ack_i) state_d = ST_RUN;
         default:     state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_RUN;
         by_pin_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (exit_ev.fire) by_pin_q <= exit_ev.by_pin;
      end
   end

   assign sys_rst_o  = (state_q == ST_EXIT_RST);
   assign iso_hold_o = (state_q == ST_LOWPWR) || (state_q == ST_ISO_WAIT) ||
                       ((state_q == ST_EXIT_RST) && !by_pin_q);

endmodule

// File: rtl/lp_exit_seq_chk.sv
module lp_exit_seq_chk #(
   parameter int RST_CYCLES = 8
) (
   input logic clk,
   input logic rst_n,
   input logic iso_ack_i,
   input logic flag_clr_i,
   input logic sys_rst_o,
   input logic iso_hold_o,
   input logic flag_wake_o,
   input logic flag_pin_o,
   input logic ret_lost_o
);

   int unsigned hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hi_cnt <= 0;
      else if (sys_rst_o) hi_cnt <= hi_cnt + 1;
      else                hi_cnt <= 0;
   end

   assert_rst_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst_o) |-> hi_cnt == RST_CYCLES);

   assert_exit_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_o) |-> (flag_wake_o && ret_lost_o));

   assert_iso_ack_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(iso_hold_o) && !sys_rst_o) |-> $past(iso_ack_i));

   assert_pin_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_rst_o && !iso_hold_o) |-> flag_pin_o);

   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wake_o && !flag_clr_i) |=> flag_wake_o);

   assert_run_no_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!iso_hold_o && !sys_rst_o) |=> !sys_rst_o);

endmodule

bind lp_exit_seq lp_exit_seq_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .iso_ack_i   (iso_ack_i),
   .flag_clr_i  (flag_clr_i),
   .sys_rst_o   (sys_rst_o),
   .iso_hold_o  (iso_hold_o),
   .flag_wake_o (flag_wake_o),
   .flag_pin_o  (flag_pin_o),
   .ret_lost_o  (ret_lost_o)
);

// File: tb/lp_exit_seq_tb_top.sv
`timescale 1ns/1ps
module lp_exit_seq_tb_top;

   localparam int SYNC = 2;
   localparam int RLEN = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lp_mode_i = 0, wake_req_i = 0, pin_rst_i = 0, iso_ack_i = 0, flag_clr_i = 0;
   logic sys_rst_o, iso_hold_o, flag_wake_o, flag_pin_o, ret_lost_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   lp_exit_seq #(.SYNC_STAGES(SYNC), .RST_CYCLES(RLEN)) dut_i (
      .clk(clk), .rst_n(rst_n), .lp_mode_i(lp_mode_i), .wake_req_i(wake_req_i),
      .pin_rst_i(pin_rst_i), .iso_ack_i(iso_ack_i), .flag_clr_i(flag_clr_i),
      .sys_rst_o(sys_rst_o), .iso_hold_o(iso_hold_o), .flag_wake_o(flag_wake_o),
      .flag_pin_o(flag_pin_o), .ret_lost_o(ret_lost_o)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic chk_flags(input string req, input logic w, input logic p, input logic l);
      chk(req, "flag_wake_o", flag_wake_o, w);
      chk(req, "flag_pin_o", flag_pin_o, p);
      chk(req, "ret_lost_o", ret_lost_o, l);
   endtask

   task automatic pulse_clear();
      flag_clr_i = 1;
      @(negedge clk);
      flag_clr_i = 0;
   endtask

   task automatic t_reset();
      chk("R1", "sys_rst_o", sys_rst_o, 0);
      chk("R1", "iso_hold_o", iso_hold_o, 0);
      chk_flags("R1", 0, 0, 0);
   endtask

   task automatic t_enter_lp();
      lp_mode_i = 1;
      @(negedge clk);
      lp_mode_i = 0;
      chk("R2", "iso_hold_o", iso_hold_o, 1);
      chk("R2", "sys_rst_o", sys_rst_o, 0);
   endtask

   task automatic t_ignored_in_run();
      wake_req_i = 1;
      pin_rst_i  = 1;
      repeat (SYNC + 4) @(negedge clk);
      chk("R9", "sys_rst_o", sys_rst_o, 0);
      chk("R9", "iso_hold_o", iso_hold_o, 0);
      chk_flags("R9", 0, 0, 0);
      wake_req_i = 0;
      pin_rst_i  = 0;
      repeat (SYNC + 2) @(negedge clk);
   endtask

   task automatic t_wake_exit();
      t_enter_lp();
      wake_req_i = 1;
      repeat (SYNC) @(negedge clk);
      chk("R3", "sys_rst_o early", sys_rst_o, 0);
      @(negedge clk);
      wake_req_i = 0;
      chk("R3", "sys_rst_o rise", sys_rst_o, 1);
      chk("R5", "iso_hold_o in reset", iso_hold_o, 1);
      chk_flags("R4", 1, 0, 1);
      iso_ack_i = 1;               // R10: acknowledge during reset is ignored
      @(negedge clk);
      iso_ack_i = 0;
      repeat (RLEN - 2) @(negedge clk);
      chk("R3", "sys_rst_o last cycle", sys_rst_o, 1);
      @(negedge clk);
      chk("R3", "sys_rst_o released", sys_rst_o, 0);
      repeat (3) @(negedge clk);
      chk("R10", "iso_hold_o after early ack", iso_hold_o, 1);
      chk("R5", "sys_rst_o while isolated", sys_rst_o, 0);
      iso_ack_i = 1;
      @(negedge clk);
      iso_ack_i = 0;
      chk("R5", "iso_hold_o after ack", iso_hold_o, 0);
      lp_mode_i = 1;               // back in run: lp entry must work again
      @(negedge clk);
      lp_mode_i = 0;
      chk("R5", "run state re-entry to low power", iso_hold_o, 1);
      wake_req_i = 1;
      repeat (SYNC + 1) @(negedge clk);
      wake_req_i = 0;
      repeat (RLEN) @(negedge clk);
      iso_ack_i = 1;
      @(negedge clk);
      iso_ack_i = 0;
   endtask

   task automatic t_clear();
      chk_flags("R8", 1, 0, 1);
      repeat (4) @(negedge clk);
      chk_flags("R8", 1, 0, 1);
      pulse_clear();
      chk_flags("R8", 0, 0, 0);
   endtask

   task automatic t_pin_exit();
      t_enter_lp();
      pin_rst_i = 1;
      repeat (SYNC + 1) @(negedge clk);
      pin_rst_i = 0;
      chk("R6", "sys_rst_o rise", sys_rst_o, 1);
      chk("R6", "iso_hold_o released", iso_hold_o, 0);
      chk_flags("R6", 1, 1, 1);
      repeat (RLEN - 1) @(negedge clk);
      chk("R6", "sys_rst_o last cycle", sys_rst_o, 1);
      @(negedge clk);
      chk("R6", "sys_rst_o released", sys_rst_o, 0);
      chk("R6", "iso_hold_o in run", iso_hold_o, 0);
      repeat (2) @(negedge clk);
      chk("R6", "no ack needed, still run", iso_hold_o, 0);
      pulse_clear();
   endtask

   task automatic t_both_with_clear();
      t_enter_lp();
      wake_req_i = 1;
      pin_rst_i  = 1;
      repeat (SYNC) @(negedge clk);
      flag_clr_i = 1;              // R8: clear coincides with exit event
      @(negedge clk);
      flag_clr_i = 0;
      wake_req_i = 0;
      pin_rst_i  = 0;
      chk("R7", "sys_rst_o", sys_rst_o, 1);
      chk("R7", "iso_hold_o pin wins", iso_hold_o, 0);
      chk_flags("R7", 1, 1, 1);
      repeat (RLEN) @(negedge clk);
      chk("R7", "back to run", iso_hold_o | sys_rst_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_ignored_in_run();
      t_wake_exit();
      t_clear();
      t_pin_exit();
      t_both_with_clear();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule